// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block watches the serial data link carried in a line frame, one bit per strobe, and looks for 16-bit bit-oriented messages. Each message has a header of eight ones, a zero separator, a six-bit code and a closing zero. The block filters out transients. A code is reported only when it has filled enough recent message positions, and only when it differs from the code reported last.

Once the first message is found, the receiver locks onto 16-bit message positions. It keeps a ten-deep record of which positions held the current candidate code. When eight of those positions hold hits and the candidate is new, the code is latched onto the output. A sticky status bit is then set, unless the mask bit holds it off, and that bit drives an interrupt request. Software reads the code and clears the status bit with a read strobe.

Top module: `bom_receiver`

## Requirements
- R1: A message is 16 bits, received first-bit-first as 11111111, 0, c5..c0, 0. The first received code bit is the code MSB. The code 6'b111111 is an idle marker and is never taken as a candidate.
- R2: After reset, `msgCode` is 6'b111111, and `intStatus` and `intReq` are 0.
- R3: After the first match, positions are counted on 16-bit boundaries. A code is accepted on the clock edge that samples the last bit of a position, when at least 8 of the last 10 positions held it. With back-to-back messages, this happens at the end of the 8th message.
- R4: Seven consecutive copies of a code are not accepted. Eight copies inside ten positions, with the other positions corrupted, are accepted.
- R5: A code equal to the last accepted code is never accepted again, so it neither sets the status bit nor changes `msgCode`.
- R6: A valid code that differs from the candidate and ends on a position boundary becomes the new candidate, and the hit record restarts from that one hit.
- R7: An acceptance with `intMask` = 0 sets `intStatus`. `intReq` equals `intStatus` AND NOT `intMask`.
- R8: An acceptance with `intMask` = 1 leaves `intStatus` unchanged but still updates `msgCode`.
- R9: `rdStrobe` clears `intStatus` on the next edge. When a set and a read occur on the same edge, the status bit stays set.
- R10: `msgCode` holds its value until the next acceptance.
- R11: When the hit record holds no hits, the receiver returns to hunting. A new message at any bit phase is then found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitValid | input | 1 | One-cycle strobe marking a data link bit |
| bitIn | input | 1 | Data link bit, valid with `bitValid` |
| intMask | input | 1 | 1 blocks the interrupt for this source |
| rdStrobe | input | 1 | Status read strobe; clears `intStatus` |
| msgCode | output | 6 | Last accepted code; 6'b111111 when none |
| intStatus | output | 1 | Sticky interrupt status bit |
| intReq | output | 1 | Interrupt request |

## Verification
A wrong hit record or candidate shows at the ports as an acceptance at the wrong message count. The code then lands one or more 16-bit positions early or late, or never lands at all. The bench therefore samples `msgCode` and `intStatus` immediately after the final bit of the 7th and 8th copies. A lost lock shows as no acceptance at the end of the sequence. A bad last-accepted register shows as a repeated interrupt on an old code, which appears within eight messages.

// File: rtl/bomr_pkg.sv
package bomr_pkg;

  typedef struct packed {
    logic loadCand;   // take the window code as the new candidate, restart record
    logic histShift;  // push one position result into the record
    logic histHit;    // value pushed on histShift
    logic accept;     // latch candidate as the reported code
  } bomrStrobe_t;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } bomrState_t;

endpackage

// File: rtl/bomr_datapath.sv
module bomr_datapath
  import bomr_pkg::*;
#(
  parameter int FLAG_BITS = 8,
  parameter int CODE_BITS = 6,
  parameter int HIST_LEN  = 10,
  parameter int VOTE_MIN  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bitValid,
  input  logic                 bitIn,
  input  logic                 intMask,
  input  logic                 rdStrobe,
  input  bomrStrobe_t          strobe,
  output logic                 patValid,
  output logic                 patHit,
  output logic                 voteIfHit,
  output logic                 candNew,
  output logic                 histEmptyOnMiss,
  output logic [CODE_BITS-1:0] codeOut,
  output logic                 statusBit
);

  localparam int MSG_BITS = FLAG_BITS + CODE_BITS + 2;
  localparam int SEP_POS  = CODE_BITS + 1;
  localparam logic [CODE_BITS-1:0] IDLE_CODE = '1;

  logic [MSG_BITS-1:0]  shiftReg;
  logic [MSG_BITS-1:0]  winNext;
  logic [CODE_BITS-1:0] winCode;
  logic [CODE_BITS-1:0] cand;
  logic [HIST_LEN-1:0]  hist;
  logic [HIST_LEN-1:0]  histWithHit;
  logic                 flagOk;
  logic                 statusSet;

  // Window as it will look once the current bit is shifted in
  assign winNext = {shiftReg[MSG_BITS-2:0], bitIn};
  assign winCode = winNext[CODE_BITS:1];
  assign flagOk  = &winNext[MSG_BITS-1 -: FLAG_BITS];

  assign patValid = bitValid && flagOk && !winNext[SEP_POS] && !winNext[0]
                    && (winCode != IDLE_CODE);
  assign patHit   = patValid && (winCode == cand);

  assign histWithHit     = {hist[HIST_LEN-2:0], 1'b1};
  assign voteIfHit       = ($countones(histWithHit) >= VOTE_MIN);
  assign histEmptyOnMiss = (hist[HIST_LEN-2:0] == '0);
  assign candNew         = (cand != codeOut);
  assign statusSet       = strobe.accept && !intMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (bitValid) begin
      shiftReg <= winNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= IDLE_CODE;
      hist <= '0;
    end else if (strobe.loadCand) begin
      cand <= winCode;
      hist <= {{(HIST_LEN-1){1'b0}}, 1'b1};
    end else if (strobe.histShift) begin
      hist <= {hist[HIST_LEN-2:0], strobe.histHit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeOut <= IDLE_CODE;
    end else if (strobe.accept) begin
      codeOut <= cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusBit <= 1'b0;
    end else if (statusSet) begin
      statusBit <= 1'b1;
    end else if (rdStrobe) begin
      statusBit <= 1'b0;
    end
  end

  AST_ACCEPT_HAS_VOTES: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.accept |=> ($countones(hist) >= VOTE_MIN)); // R3
  AST_ACCEPT_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.accept |=> (codeOut != $past(codeOut))); // R5
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.accept && !intMask) |=> statusBit); // R7
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !(strobe.accept && !intMask)) |=> !statusBit); // R9
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.accept |=> $stable(codeOut)); // R10

endmodule

// File: rtl/bomr_control.sv
module bomr_control
  import bomr_pkg::*;
#(
  parameter int MSG_BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bitValid,
  input  logic        patValid,
  input  logic        patHit,
  input  logic        voteIfHit,
  input  logic        candNew,
  input  logic        histEmptyOnMiss,
  output bomrStrobe_t strobe,
  output logic        tracking
);

  localparam int CNT_W = $clog2(MSG_BITS);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(MSG_BITS - 1);

  bomrState_t       state;
  logic [CNT_W-1:0] slotCnt;
  logic             slotEnd;
  logic             dropLock;

  assign tracking = (state == ST_TRACK);
  assign slotEnd  = tracking && bitValid && (slotCnt == SLOT_LAST);
  assign dropLock = slotEnd && !patHit && !patValid && histEmptyOnMiss;

  always_comb begin
    strobe = '0;
    if (state == ST_HUNT) begin
      strobe.loadCand = bitValid && patValid;
    end else if (slotEnd) begin
      if (patHit) begin
        strobe.histShift = 1'b1;
        strobe.histHit   = 1'b1;
        strobe.accept    = voteIfHit && candNew;
      end else if (patValid) begin
        strobe.loadCand  = 1'b1;
      end else begin
        strobe.histShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      slotCnt <= '0;
    end else if (state == ST_HUNT) begin
      if (strobe.loadCand) begin
        state   <= ST_TRACK;
        slotCnt <= '0;
      end
    end else if (bitValid) begin
      slotCnt <= (slotCnt == SLOT_LAST) ? '0 : slotCnt + 1'b1;
      if (dropLock) begin
        state <= ST_HUNT;
      end
    end
  end

  AST_HUNT_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |=> (slotCnt == '0)); // R11
  AST_ACCEPT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.accept |-> (patHit && slotEnd)); // R3

endmodule

// File: rtl/bom_receiver.sv
module bom_receiver
  import bomr_pkg::*;
#(
  parameter int FLAG_BITS = 8,
  parameter int CODE_BITS = 6,
  parameter int HIST_LEN  = 10,
  parameter int VOTE_MIN  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bitValid,
  input  logic                 bitIn,
  input  logic                 intMask,
  input  logic                 rdStrobe,
  output logic [CODE_BITS-1:0] msgCode,
  output logic                 intStatus,
  output logic                 intReq
);

  localparam int MSG_BITS = FLAG_BITS + CODE_BITS + 2;

  bomrStrobe_t strobe;
  logic patValid, patHit, voteIfHit, candNew, histEmptyOnMiss, tracking;

  bomr_control #(.MSG_BITS(MSG_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid),
    .patValid(patValid), .patHit(patHit), .voteIfHit(voteIfHit),
    .candNew(candNew), .histEmptyOnMiss(histEmptyOnMiss),
    .strobe(strobe), .tracking(tracking)
  );

  bomr_datapath #(
    .FLAG_BITS(FLAG_BITS), .CODE_BITS(CODE_BITS),
    .HIST_LEN(HIST_LEN), .VOTE_MIN(VOTE_MIN)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .intMask(intMask), .rdStrobe(rdStrobe), .strobe(strobe),
    .patValid(patValid), .patHit(patHit), .voteIfHit(voteIfHit),
    .candNew(candNew), .histEmptyOnMiss(histEmptyOnMiss),
    .codeOut(msgCode), .statusBit(intStatus)
  );

  assign intReq = intStatus && !intMask;

  AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    intMask |-> !intReq); // R7
  AST_NO_ACCEPT_WHILE_HUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    !tracking |-> !strobe.accept); // R11

endmodule

// File: tb/bom_receiver_bench.sv
module bom_receiver_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b1;
  logic       intMask = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [5:0] msgCode;
  logic       intStatus;
  logic       intReq;

  int checks = 0;
  int fails  = 0;
  logic [5:0] lastAcc = 6'h3F;

  always #2 clk = ~clk;   // 250 MHz

  bom_receiver u_bom_receiver (
    .clk(clk), .rst_n(rst_n), .bitValid(bitValid), .bitIn(bitIn),
    .intMask(intMask), .rdStrobe(rdStrobe),
    .msgCode(msgCode), .intStatus(intStatus), .intReq(intReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expAccept(input int hits, input logic [5:0] code,
                                   input logic [5:0] last);
    return (hits >= 8) && (code != last) && (code != 6'h3F);
  endfunction

  function automatic bit expReq(input bit status, input bit mask);
    return status && !mask;
  endfunction

  task automatic sendBit(input logic b, input bit rd = 1'b0);
    bitValid = 1'b1;
    bitIn    = b;
    rdStrobe = rd;
    @(negedge clk);
    bitValid = 1'b0;
    rdStrobe = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic sendMsg(input logic [5:0] code, input bit rdLast = 1'b0);
    logic [15:0] m;
    m = {8'hFF, 1'b0, code, 1'b0};
    for (int i = 15; i >= 0; i--) sendBit(m[i], (i == 0) && rdLast);
  endtask

  task automatic sendOnes(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic doRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R2 code reset", msgCode, 6'h3F);
    check("R2 status reset", intStatus, 0);
    check("R2 req reset", intReq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R3/R4: seven copies not accepted, eighth accepts
    for (int k = 0; k < 7; k++) sendMsg(6'b100110);
    check("R4 seven copies no accept", msgCode, 6'h3F);
    check("R4 seven copies no status", intStatus, 0);
    sendMsg(6'b100110);
    check("R3 R1 eighth copy code", msgCode, 6'b100110);
    check("R7 status set", intStatus, 1);
    check("R7 req follows status", intReq, 1);
    intMask = 1'b1; #1;
    check("R7 req masked", intReq, 0);
    intMask = 1'b0;
    doRead();
    check("R9 read clears", intStatus, 0);
    lastAcc = 6'b100110;

    // R5: repeats of accepted code, after idle
    sendOnes(176);
    for (int k = 0; k < 10; k++) sendMsg(6'b100110);
    check("R5 same code no status", intStatus, 0);
    check("R10 code held", msgCode, 6'b100110);
    sendOnes(176);

    // R1 idle code never candidate
    for (int k = 0; k < 10; k++) sendMsg(6'h3F);
    check("R1 idle code ignored", intStatus, 0);
    sendOnes(176);

    // R4: eight hits among nine positions with one corrupted
    for (int k = 0; k < 5; k++) sendMsg(6'b001011);
    sendOnes(16);
    for (int k = 0; k < 2; k++) sendMsg(6'b001011);
    check("R4 seven hits with gap", intStatus, 0);
    sendMsg(6'b001011);
    check("R4 eight of nine accepted", msgCode, 6'b001011);
    check("R4 status after gap", intStatus, 1);
    lastAcc = 6'b001011;

    // R9: set and read in the same cycle keeps status
    doRead();
    sendOnes(176);
    for (int k = 0; k < 7; k++) sendMsg(6'b010101);
    sendMsg(6'b010101, 1'b1);
    check("R9 set wins over read", intStatus, 1);
    doRead();
    lastAcc = 6'b010101;
    sendOnes(176);

    // R6: candidate restart
    for (int k = 0; k < 5; k++) sendMsg(6'b000111);
    for (int k = 0; k < 7; k++) sendMsg(6'b110000);
    check("R6 no accept before restart count", msgCode, 6'b010101);
    sendMsg(6'b110000);
    check("R6 new candidate accepted", msgCode, 6'b110000);
    doRead();
    lastAcc = 6'b110000;
    sendOnes(176);

    // R8: masked acceptance
    intMask = 1'b1;
    for (int k = 0; k < 8; k++) sendMsg(6'b011100);
    check("R8 masked code updated", msgCode, 6'b011100);
    check("R8 masked no status", intStatus, 0);
    intMask = 1'b0;
    lastAcc = 6'b011100;
    sendOnes(176);

    // R11: message at an odd bit phase after lock dropped
    sendOnes(5);
    for (int k = 0; k < 8; k++) sendMsg(6'b101000);
    check("R11 odd phase accepted", msgCode, 6'b101000);
    doRead();
    lastAcc = 6'b101000;
    sendOnes(176);

    // Constrained random scenarios
    for (int s = 0; s < 14; s++) begin
      logic [5:0] code;
      int reps;
      bit mask, acc;
      code = 6'($urandom_range(0, 62));
      if (s % 4 == 0) code = lastAcc;
      reps = $urandom_range(5, 10);
      mask = ($urandom_range(0, 3) == 0);
      intMask = mask;
      for (int k = 0; k < reps; k++) sendMsg(code);
      acc = expAccept(reps, code, lastAcc);
      if (acc) lastAcc = code;
      check("R3 R5 random code", msgCode, lastAcc);
      check("R7 R8 random status", intStatus, acc && !mask);
      check("R7 random req", intReq, expReq(acc && !mask, mask));
      intMask = 1'b0;
      doRead();
      sendOnes(176);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule